// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This unit turns the operand bytes of a memory-referencing instruction into the final 16-bit address an 8-bit CPU must access. It covers eight addressing modes: zero page; zero page plus X; zero page plus Y; absolute; absolute plus X; absolute plus Y; pointer-from-page-zero after adding X; and pointer-from-page-zero then plus Y. A companion flag marks each access as a read or as a write/read-modify-write. Alongside the address, the unit reports three things: whether indexing moved the address into another 256-byte page, whether the memory sequencer must issue a throw-away read (and at which address), and how many extra cycles the access costs.

The sequencer starts the unit with a one-cycle `start` pulse that carries the mode, the access kind and both index registers. The unit then takes bytes one at a time over a valid/ready input stream. `fetch_zp` tells the supplier where each byte must come from. When it is low, the byte is the next instruction byte, and `pc_step` pulses as the byte is taken so the program counter can advance. When it is high, the byte is read from page zero at `fetch_addr`. A byte moves only on a cycle where `in_valid` and `in_ready` are both high. The supplier may hold `in_valid` low for any number of cycles, and the unit simply waits. `in_ready` is high only while the unit expects a byte. `done` pulses for one cycle with the results, and the results stay on the outputs until the next `done`.

Top module: `ea_gen`

## Requirements
- R1: While `busy` is low, a `start` pulse latches `mode`, `wr_mode`, `x_idx` and `y_idx`, and `busy` then stays high until the cycle after `done`. While `busy` is high, `start` and all four of those inputs are ignored. Mode codes: 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 pointer at (operand+X), 7 pointer at operand then +Y. `wr_mode` is 1 for write or read-modify-write.
- R2: Absolute modes take two instruction bytes, the low address byte first. Every other mode takes one instruction byte. `pc_step` pulses once for each instruction byte accepted and never for a page-zero byte.
- R3: The zero-page modes give `ea` = {8'h00, (operand + index) mod 256}, where the index is 0, X or Y depending on the mode.
- R4: Mode 6 fetches two page-zero bytes: the low byte at (operand+X) mod 256, then the high byte at the next location mod 256. `ea` is that pointer, with no dummy read and no penalty.
- R5: Mode 7 fetches the pointer's low byte at the operand and its high byte at (operand+1) mod 256. `ea` is (pointer + Y) mod 65536.
- R6: For reads in modes 4, 5 and 7, a page crossing sets `dummy_en`, sets `dummy_addr` = `ea` with bit 8 inverted, and sets `penalty` to 1. With no crossing, `dummy_en` and `penalty` are both 0.
- R7: For writes in modes 4, 5 and 7, `dummy_en` is always 1, `dummy_addr` is {base high byte, `ea` low byte}, and `penalty` is 0.
- R8: `page_cross` is 1 exactly when the base high byte differs from the `ea` high byte in modes 4, 5 and 7. In all other modes it is 0, as are `dummy_en` and `penalty`.
- R9: `in_ready` is high only while a byte is expected. A byte is consumed only when `in_valid` and `in_ready` are high together. Holding `in_valid` low stalls the unit without changing its result.
- R10: `done` is high for exactly one cycle, the cycle after the final byte is accepted. The results hold until the next `done`.
- R11: While reset is asserted and after it is released, `done`, `busy` and `in_ready` are low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new address computation |
| mode | input | 3 | Addressing mode code (see R1) |
| wr_mode | input | 1 | 1 for write or read-modify-write access |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| in_valid | input | 1 | Byte available on `in_data` |
| in_ready | output | 1 | Unit will take a byte this cycle |
| in_data | input | 8 | Instruction or page-zero byte |
| fetch_zp | output | 1 | Next byte must come from page zero |
| fetch_addr | output | 8 | Page-zero location of the next byte |
| pc_step | output | 1 | Instruction byte accepted this cycle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid pulse |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexing crossed a page boundary |
| dummy_en | output | 1 | A dummy read is required |
| dummy_addr | output | 16 | Address of the dummy read |
| penalty | output | 2 | Extra cycles due to indexing |

## Verification
The bench targets four kinds of wraparound, each of which a wrong design would send into page one or to address 0x10000. These are a zero-page sum past 0xFF, a pointer whose low byte sits at 0xFF, an operand+X that wraps, and a Y addition that passes 0xFFFF. It sets read and write variants of the same crossing side by side. A design that mixed them up would charge a penalty on writes or drop the always-present dummy read. It also checks that the read dummy address keeps bit 8 inverted, not the base page. Random stalls and stray `start` pulses mid-operation expose a design that double-counts a byte or re-latches its indices.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    AM_ZP   = 3'd0,
    AM_ZPX  = 3'd1,
    AM_ZPY  = 3'd2,
    AM_ABS  = 3'd3,
    AM_ABSX = 3'd4,
    AM_ABSY = 3'd5,
    AM_INDX = 3'd6,
    AM_INDY = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPLO = 3'd1,
    S_OPHI = 3'd2,
    S_PLO  = 3'd3,
    S_PHI  = 3'd4,
    S_DONE = 3'd5
  } seq_e;

  function automatic logic is_zp_mode(amode_e m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction

  function automatic logic is_idx16_mode(amode_e m);
    return (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_INDY);
  endfunction
endpackage

// File: rtl/ea_gen_seq.sv
module ea_gen_seq
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  amode_e        mode_q,
  input  logic [DW-1:0] x_q,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          fetch_zp,
  output logic [DW-1:0] fetch_addr,
  output logic          pc_step,
  output logic          busy,
  output logic          finish,
  output logic [AW-1:0] base_w
);
  seq_e          state;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] ptr_q;
  logic          accept;

  assign in_ready = (state == S_OPLO) || (state == S_OPHI) ||
                    (state == S_PLO)  || (state == S_PHI);
  assign accept   = in_valid && in_ready;
  assign fetch_zp = (state == S_PLO) || (state == S_PHI);
  assign fetch_addr = (state == S_PHI) ? ptr_q + DW'(1) : ptr_q;
  assign pc_step  = accept && ((state == S_OPLO) || (state == S_OPHI));
  assign busy     = (state != S_IDLE);

  always_comb begin
    finish = 1'b0;
    if (accept) begin
      unique case (state)
        S_OPLO:        finish = is_zp_mode(mode_q);
        S_OPHI, S_PHI: finish = 1'b1;
        default:       finish = 1'b0;
      endcase
    end
  end

  assign base_w = (state == S_OPLO) ? {{DW{1'b0}}, in_data} : {in_data, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lo_q  <= '0;
      ptr_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (go) state <= S_OPLO;
        S_OPLO: if (accept) begin
          unique case (mode_q)
            AM_ZP, AM_ZPX, AM_ZPY: state <= S_DONE;
            AM_ABS, AM_ABSX, AM_ABSY: begin
              lo_q  <= in_data;
              state <= S_OPHI;
            end
            AM_INDX: begin
              ptr_q <= in_data + x_q;
              state <= S_PLO;
            end
            default: begin
              ptr_q <= in_data;
              state <= S_PLO;
            end
          endcase
        end
        S_OPHI: if (accept) state <= S_DONE;
        S_PLO: if (accept) begin
          lo_q  <= in_data;
          state <= S_PHI;
        end
        S_PHI:  if (accept) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2,
  localparam int AW = 2 * DW
) (
  input  amode_e        mode_q,
  input  logic          wr_q,
  input  logic [DW-1:0] x_q,
  input  logic [DW-1:0] y_q,
  input  logic [AW-1:0] base_w,
  output logic [AW-1:0] ea_c,
  output logic          cross_c,
  output logic          dummy_en_c,
  output logic [AW-1:0] dummy_addr_c,
  output logic [PW-1:0] penalty_c
);
  logic [DW-1:0] idx;
  logic [AW-1:0] sum16;
  logic [DW-1:0] zp_sum;
  logic          idx16;

  always_comb begin
    unique case (mode_q)
      AM_ZPX, AM_ABSX:          idx = x_q;
      AM_ZPY, AM_ABSY, AM_INDY: idx = y_q;
      default:                  idx = '0;
    endcase
  end

  assign idx16  = is_idx16_mode(mode_q);
  assign sum16  = base_w + {{DW{1'b0}}, idx};
  assign zp_sum = base_w[DW-1:0] + idx;

  always_comb begin
    ea_c         = is_zp_mode(mode_q) ? {{DW{1'b0}}, zp_sum} : sum16;
    cross_c      = idx16 && (base_w[AW-1:DW] != sum16[AW-1:DW]);
    dummy_en_c   = 1'b0;
    dummy_addr_c = '0;
    penalty_c    = '0;
    if (idx16) begin
      if (wr_q) begin
        dummy_en_c   = 1'b1;
        dummy_addr_c = {base_w[AW-1:DW], sum16[DW-1:0]};
      end else if (cross_c) begin
        dummy_en_c   = 1'b1;
        dummy_addr_c = sum16 ^ (AW'(1) << DW);
        penalty_c    = PW'(1);
      end
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic          wr_mode,
  input  logic [DW-1:0] x_idx,
  input  logic [DW-1:0] y_idx,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          fetch_zp,
  output logic [DW-1:0] fetch_addr,
  output logic          pc_step,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          page_cross,
  output logic          dummy_en,
  output logic [AW-1:0] dummy_addr,
  output logic [PW-1:0] penalty
);
  amode_e        mode_q;
  logic          wr_q;
  logic [DW-1:0] x_q, y_q;
  logic          go, finish;
  logic [AW-1:0] base_w, ea_c, dummy_addr_c;
  logic          cross_c, dummy_en_c;
  logic [PW-1:0] penalty_c;

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= AM_ZP;
      wr_q   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (go) begin
      mode_q <= amode_e'(mode);
      wr_q   <= wr_mode;
      x_q    <= x_idx;
      y_q    <= y_idx;
    end
  end

  ea_gen_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .mode_q(mode_q), .x_q(x_q),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fetch_zp(fetch_zp), .fetch_addr(fetch_addr), .pc_step(pc_step),
    .busy(busy), .finish(finish), .base_w(base_w)
  );

  ea_gen_calc #(.DW(DW), .PW(PW)) u_calc (
    .mode_q(mode_q), .wr_q(wr_q), .x_q(x_q), .y_q(y_q), .base_w(base_w),
    .ea_c(ea_c), .cross_c(cross_c), .dummy_en_c(dummy_en_c),
    .dummy_addr_c(dummy_addr_c), .penalty_c(penalty_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      ea         <= '0;
      page_cross <= 1'b0;
      dummy_en   <= 1'b0;
      dummy_addr <= '0;
      penalty    <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        ea         <= ea_c;
        page_cross <= cross_c;
        dummy_en   <= dummy_en_c;
        dummy_addr <= dummy_addr_c;
        penalty    <= penalty_c;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          in_valid,
  input logic          in_ready,
  input logic          fetch_zp,
  input logic          pc_step,
  input amode_e        mode_q,
  input logic          wr_q,
  input logic [AW-1:0] ea,
  input logic          page_cross,
  input logic          dummy_en,
  input logic [AW-1:0] dummy_addr,
  input logic [PW-1:0] penalty
);
  localparam logic [AW-1:0] BIT8 = AW'(1) << DW;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready));

  p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |-> !fetch_zp);

  p_zp_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_zp_mode(mode_q)) |-> (ea[AW-1:DW] == '0));

  p_rd_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q && penalty != '0) |->
      (page_cross && dummy_en && dummy_addr == (ea ^ BIT8)));

  p_wr_dummy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_q && is_idx16_mode(mode_q)) |->
      (dummy_en && penalty == '0 && dummy_addr[DW-1:0] == ea[DW-1:0]));

  p_no_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_idx16_mode(mode_q)) |-> (!page_cross && !dummy_en && penalty == '0));
endmodule

bind ea_gen ea_gen_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .in_valid(in_valid),
  .in_ready(in_ready), .fetch_zp(fetch_zp), .pc_step(pc_step),
  .mode_q(mode_q), .wr_q(wr_q), .ea(ea), .page_cross(page_cross),
  .dummy_en(dummy_en), .dummy_addr(dummy_addr), .penalty(penalty)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        wr_mode = 1'b0;
  logic [7:0]  x_idx = '0, y_idx = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        fetch_zp;
  logic [7:0]  fetch_addr;
  logic        pc_step, busy, done;
  logic [15:0] ea, dummy_addr;
  logic        page_cross, dummy_en;
  logic [1:0]  penalty;

  int checks = 0;
  int errors = 0;
  logic [7:0] zp_mem [256];

  always #2 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_mode(wr_mode),
    .x_idx(x_idx), .y_idx(y_idx), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fetch_zp(fetch_zp), .fetch_addr(fetch_addr),
    .pc_step(pc_step), .busy(busy), .done(done), .ea(ea),
    .page_cross(page_cross), .dummy_en(dummy_en), .dummy_addr(dummy_addr),
    .penalty(penalty)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected result packed as {ea, cross, den, daddr, pen}
  function automatic logic [35:0] model(input logic [2:0] m, input logic w,
      input logic [7:0] xv, yv, b0, b1);
    logic [15:0] base, sum, e, da;
    logic [7:0]  idx, p;
    logic        cr, de;
    logic [1:0]  pn;
    idx = (m == 3'd1 || m == 3'd4) ? xv :
          (m == 3'd2 || m == 3'd5 || m == 3'd7) ? yv : 8'h00;
    cr = 1'b0; de = 1'b0; da = '0; pn = '0;
    if (m <= 3'd2) begin
      p = b0 + idx;
      e = {8'h00, p};
    end else begin
      if (m == 3'd6) begin
        p = b0 + xv;
        base = {zp_mem[8'(p + 8'd1)], zp_mem[p]};
      end else if (m == 3'd7) begin
        base = {zp_mem[8'(b0 + 8'd1)], zp_mem[b0]};
      end else begin
        base = {b1, b0};
      end
      sum = base + {8'h00, idx};
      e = sum;
      if (m == 3'd4 || m == 3'd5 || m == 3'd7) begin
        cr = base[15:8] != sum[15:8];
        if (w) begin
          de = 1'b1; da = {base[15:8], sum[7:0]};
        end else if (cr) begin
          de = 1'b1; da = sum ^ 16'h0100; pn = 2'd1;
        end
      end
    end
    return {e, cr, de, da, pn};
  endfunction

  task automatic run_one(input logic [2:0] m, input logic w,
      input logic [7:0] xv, yv, b0, b1, input bit stall, input bit poke);
    logic [35:0] exp;
    int ops, zps, pcs, guard;
    logic [15:0] ea_hold;
    exp = model(m, w, xv, yv, b0, b1);
    @(negedge clk);
    mode = m; wr_mode = w; x_idx = xv; y_idx = yv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x_idx = 8'($urandom); y_idx = 8'($urandom);
    mode = 3'($urandom); wr_mode = 1'($urandom);
    ops = 0; zps = 0; pcs = 0; guard = 0;
    while (!done && guard < 60) begin
      guard++;
      start = poke;
      if (in_ready && !(stall && ($urandom % 3 == 0))) begin
        in_valid = 1'b1;
        in_data = fetch_zp ? zp_mem[fetch_addr] : (ops == 0 ? b0 : b1);
      end else begin
        in_valid = 1'b0;
        in_data = 8'($urandom);
      end
      @(posedge clk);
      if (pc_step) pcs++;
      if (in_valid && in_ready) begin
        if (fetch_zp) zps++; else ops++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;
    chk(done, "R10 done seen", 32'(done), 1);
    chk(ea == exp[35:20], "R3/R4/R5 ea", ea, exp[35:20]);
    chk(page_cross == exp[19], "R8 page_cross", page_cross, exp[19]);
    chk(dummy_en == exp[18], "R6/R7 dummy_en", dummy_en, exp[18]);
    if (exp[18]) chk(dummy_addr == exp[17:2], "R6/R7 dummy_addr", dummy_addr, exp[17:2]);
    chk(penalty == exp[1:0], "R6/R7 penalty", penalty, exp[1:0]);
    chk(ops == ((m >= 3'd3 && m <= 3'd5) ? 2 : 1), "R2 instr bytes", ops,
        (m >= 3'd3 && m <= 3'd5) ? 2 : 1);
    chk(pcs == ops, "R2 pc_step count", pcs, ops);
    chk(zps == ((m >= 3'd6) ? 2 : 0), "R4 zp fetches", zps, (m >= 3'd6) ? 2 : 0);
    ea_hold = ea;
    @(negedge clk);
    chk(!done && ea == ea_hold, "R10 single pulse and hold", {15'd0, done, ea}, {16'd0, ea_hold});
    chk(!busy && !in_ready, "R1 idle after done", {busy, in_ready}, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) zp_mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!done && !busy && !in_ready && ea == 0 && !dummy_en && penalty == 0,
        "R11 reset state", {done, busy, in_ready, dummy_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !in_ready, "R11 after release", {done, busy, in_ready}, 0);
    // R9: idle unit takes no byte
    in_valid = 1'b1; in_data = 8'h55;
    @(negedge clk);
    chk(!in_ready && !pc_step && !busy, "R9 ready low when idle", {in_ready, pc_step}, 0);
    in_valid = 1'b0;

    // directed corners
    run_one(3'd4, 1'b0, 8'h20, 8'h00, 8'hF0, 8'h12, 0, 0); // R6 read cross
    run_one(3'd4, 1'b1, 8'h20, 8'h00, 8'hF0, 8'h12, 0, 0); // R7 write cross
    run_one(3'd5, 1'b0, 8'h00, 8'h05, 8'h10, 8'h34, 0, 0); // R6 no cross
    run_one(3'd5, 1'b1, 8'h00, 8'h05, 8'h10, 8'h34, 0, 0); // R7 write no cross
    run_one(3'd1, 1'b0, 8'h20, 8'h00, 8'hF0, 8'h00, 0, 0); // R3 wrap
    run_one(3'd2, 1'b1, 8'h00, 8'hFF, 8'h01, 8'h00, 0, 0); // R3 wrap via Y
    run_one(3'd6, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0); // R4 pointer at FF
    run_one(3'd6, 1'b0, 8'h80, 8'h00, 8'h90, 8'h00, 1, 1); // R4 operand+X wraps, R1 poke
    zp_mem[8'h40] = 8'hF0; zp_mem[8'h41] = 8'hFF;
    run_one(3'd7, 1'b0, 8'h00, 8'h20, 8'h40, 8'h00, 0, 0); // R5 16-bit wrap
    run_one(3'd7, 1'b1, 8'h00, 8'h20, 8'h40, 8'h00, 1, 0); // R7 ind-Y write
    run_one(3'd0, 1'b0, 8'hAA, 8'hBB, 8'h7E, 8'h00, 1, 1); // R3 plain, R9 stalls
    run_one(3'd3, 1'b1, 8'hFF, 8'hFF, 8'hCD, 8'hAB, 1, 0); // R2 absolute order

    for (int n = 0; n < 300; n++) begin
      run_one(3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom), ($urandom % 4 == 0));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule